// File: doc/BRIEF.md
# Bit-Slice Ripple ALU

A purely combinational arithmetic and logic unit. It is built from identical one-bit slices chained through their carries. Each slice first conditions its two operand bits through optional complement controls. It then offers three shared paths: a bitwise AND, a bitwise OR and a full-adder sum. A two-bit select picks one of these paths. The adder's carry is always computed and passed to the next slice, whichever path is selected.

Inverting both operands turns the AND path into NOR and the OR path into NAND, by De Morgan's laws, without any further gating. Subtraction uses the add path. The subtrahend is complemented and the carry input is set to 1, which adds the two's complement of the subtrahend. The word width is a parameter, with a default of four slices.

Top module: `alu_ripple`

## Requirements
- R1: With select code 00, each result bit is the AND of the conditioned a bit and the conditioned b bit.
- R2: With select code 01, each result bit is the OR of the conditioned a bit and the conditioned b bit.
- R3: With select code 10, the result is the low WIDTH bits of conditioned a plus conditioned b plus carry_in.
- R4: With select code 11, the result is all zeros.
- R5: When inv_a is 1, operand a is complemented before it reaches every path, including the carry. When inv_b is 1, operand b is complemented in the same way.
- R6: With both invert controls at 1, select 00 yields NOR(a,b) and select 01 yields NAND(a,b).
- R7: With inv_a at 0, inv_b at 1, carry_in at 1 and select 10, the result is (a - b) mod 2^WIDTH. In that case carry_out is 1 exactly when a >= b as unsigned values.
- R8: For every select code, carry_out is 1 exactly when conditioned a + conditioned b + carry_in is at least 2^WIDTH.
- R9: Bit 0 of each bus is the least significant bit. carry_in enters slice 0, each slice's carry feeds the slice above it, and carry_out leaves the top slice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand, bit 0 is the LSB |
| op_b | input | WIDTH | Second operand, bit 0 is the LSB |
| op_sel | input | 2 | Path select: 00 AND, 01 OR, 10 sum, 11 zero |
| inv_a | input | 1 | Complement op_a before all paths |
| inv_b | input | 1 | Complement op_b before all paths |
| carry_in | input | 1 | Carry into slice 0 |
| result | output | WIDTH | Selected path output |
| carry_out | output | 1 | Carry out of the top slice |

## Verification
The bench builds the block with its default WIDTH of 4. This makes the input space only 8192 combinations, so every pairing of operands, select code, invert controls and carry input is applied once. Each case is compared against a wider integer model. The exhaustive sweep reaches the full-length carry ripple (all ones plus a carry in), the unsigned borrow boundary of subtraction, and the unused select code under every invert setting.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_NONE = 2'b11
  } alu_sel_e;

  function automatic logic bit_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  function automatic logic bit_carry(input logic x, input logic y, input logic c);
    return (x & y) | (c & (x | y));
  endfunction

  // Count of set inputs; used by checks to restate the carry rule another way.
  function automatic int unsigned ones3(input logic x, input logic y, input logic c);
    return int'(x) + int'(y) + int'(c);
  endfunction

endpackage

// File: rtl/alu_operand_cond.sv
module alu_operand_cond (
  input  logic raw_bit,
  input  logic flip,
  output logic cond_bit
);
  always_comb cond_bit = raw_bit ^ flip;
endmodule

// File: rtl/alu_full_adder.sv
module alu_full_adder
  import alu_pkg::*;
(
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic s,
  output logic cout
);
  always_comb begin
    s    = bit_sum(x, y, cin);
    cout = bit_carry(x, y, cin);
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic       a_bit,
  input  logic       b_bit,
  input  logic       inv_a,
  input  logic       inv_b,
  input  logic [1:0] sel,
  input  logic       cin,
  output logic       res,
  output logic       cout
);
  logic a_c, b_c, sum_w;

  alu_operand_cond u_cond_a (.raw_bit(a_bit), .flip(inv_a), .cond_bit(a_c));
  alu_operand_cond u_cond_b (.raw_bit(b_bit), .flip(inv_b), .cond_bit(b_c));

  alu_full_adder u_fa (.x(a_c), .y(b_c), .cin(cin), .s(sum_w), .cout(cout));

  always_comb begin
    unique case (alu_sel_e'(sel))
      SEL_AND:  res = a_c & b_c;
      SEL_OR:   res = a_c | b_c;
      SEL_SUM:  res = sum_w;
      default:  res = 1'b0;
    endcase
  end

  // Checks beside the slice logic
  always_comb begin
    assert_slice_carry_R8: assert (cout == (ones3(a_c, b_c, cin) >= 2));
    if (sel == SEL_NONE)
      assert_unused_sel_zero_R4: assert (res == 1'b0);
    if (inv_a && inv_b && sel == SEL_AND)
      assert_nor_form_R6: assert (res == ~(a_bit | b_bit));
    if (inv_a && inv_b && sel == SEL_OR)
      assert_nand_form_R6: assert (res == ~(a_bit & b_bit));
    if (inv_a && sel == SEL_AND)
      assert_a_flip_R5: assert (res == (~a_bit & b_c));
  end
endmodule

// File: rtl/alu_ripple.sv
module alu_ripple
  import alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [1:0]       op_sel,
  input  logic             inv_a,
  input  logic             inv_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  localparam int CHAIN = WIDTH + 1;

  logic [CHAIN-1:0] chain;

  assign chain[0] = carry_in;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_slice u_slice (
      .a_bit(op_a[i]),
      .b_bit(op_b[i]),
      .inv_a(inv_a),
      .inv_b(inv_b),
      .sel(op_sel),
      .cin(chain[i]),
      .res(result[i]),
      .cout(chain[i+1])
    );
  end

  assign carry_out = chain[WIDTH];

  // Word-level checks against arithmetic written independently of the chain
  logic [WIDTH:0] wide_a, wide_b, wide_total;
  always_comb begin
    wide_a     = {1'b0, (inv_a ? ~op_a : op_a)};
    wide_b     = {1'b0, (inv_b ? ~op_b : op_b)};
    wide_total = wide_a + wide_b + {{WIDTH{1'b0}}, carry_in};
    assert_word_carry_R8: assert (carry_out == wide_total[WIDTH]);
    if (op_sel == SEL_SUM)
      assert_word_sum_R3: assert (result == wide_total[WIDTH-1:0]);
    if (op_sel == SEL_SUM && !inv_a && inv_b && carry_in) begin
      assert_sub_diff_R7: assert (result == WIDTH'(op_a - op_b));
      assert_sub_borrow_R7: assert (carry_out == (op_a >= op_b));
    end
  end
endmodule

// File: tb/alu_ripple_test.sv
module alu_ripple_test;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [W-1:0] a, b;
  logic [1:0]   sel;
  logic         ia, ib, ci;
  logic [W-1:0] result;
  logic         carry_out;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  alu_ripple #(.WIDTH(W)) uut (
    .op_a(a), .op_b(b), .op_sel(sel), .inv_a(ia), .inv_b(ib),
    .carry_in(ci), .result(result), .carry_out(carry_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s a=%0d b=%0d sel=%0d ia=%0d ib=%0d ci=%0d actual=%0d expected=%0d",
               req, a, b, sel, ia, ib, ci, act, exp);
    end
  endtask

  // Behavioural reference at integer width
  task automatic compare();
    int ea, eb, tot, er, ec;
    string tag;
    ea  = ia ? (~int'(a)) & 15 : int'(a);
    eb  = ib ? (~int'(b)) & 15 : int'(b);
    tot = ea + eb + int'(ci);
    ec  = tot / 16;
    case (sel)
      2'd0: er = ea & eb;
      2'd1: er = ea | eb;
      2'd2: er = tot % 16;
      default: er = 0;
    endcase
    if (sel == 2'd3) tag = "R4";
    else if (ia && ib && sel != 2'd2) tag = "R6";
    else if (sel == 2'd2 && !ia && ib && ci) begin
      tag = "R7";
      er = (int'(a) - int'(b) + 16) % 16;
      check("R7 borrow", int'(carry_out), (a >= b) ? 1 : 0);
    end
    else if (ia || ib) tag = "R5";
    else if (sel == 2'd0) tag = "R1";
    else if (sel == 2'd1) tag = "R2";
    else tag = "R3";
    check(tag, int'(result), er);
    check("R8", int'(carry_out), ec);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; sel = 2'd0; ia = 0; ib = 0; ci = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset", int'(result), 0);
    check("R8 reset", int'(carry_out), 0);

    // R9: full-length ripple, carry enters bit 0 and leaves the top
    @(posedge clk);
    a = 4'hF; b = 4'h0; sel = 2'd2; ci = 1;
    @(negedge clk);
    check("R9 ripple", int'(result), 0);
    check("R9 carry", int'(carry_out), 1);
    @(posedge clk);
    a = 4'h1; b = 4'h0; ci = 0;
    @(negedge clk);
    check("R9 lsb", int'(result), 1);

    for (int k = 0; k < 8192; k++) begin
      @(posedge clk);
      a   = k[3:0];
      b   = k[7:4];
      sel = k[9:8];
      ia  = k[10];
      ib  = k[11];
      ci  = k[12];
      @(negedge clk);
      compare();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule